// File: doc/BRIEF.md
# Byte-Oriented SPI Transceiver (Master or Slave)

This block moves one byte at a time over a four-wire synchronous serial link. A host loads a byte with a write strobe, reads the last received byte from a read buffer, and watches three status outputs: transfer active, transfer done and write collision. A set of static configuration inputs picks the role (master or slave), the bit order, the clock polarity and phase, the master bit rate, and whether the done flag drives the interrupt output.

In master mode the block derives the serial clock from the system clock through a divider with four base ratios and a halving option. It lowers its select output for the length of one byte, and shifts its byte out on the master-out line while it samples the master-in line. In slave mode an external master supplies the clock, select and data. These inputs pass through a synchroniser first, and a high select line holds the slave's bit position at zero. Both roles use one shift register and one sample counter, so each byte is exchanged in full duplex.

Top module: `spi_xcvr`

## Requirements
- R1: In master mode a write while idle starts a full-duplex exchange: the byte written leaves on `mosi_o`, and after completion `rdata` holds the byte that arrived on `miso_i`.
- R2: `cfg_lsb_first`=1 sends and assembles bit 0 first; `cfg_lsb_first`=0 sends and assembles bit 7 first. Right after a master write, `mosi_o` carries the first bit in that order.
- R3: The master half-period of SCK, in system clocks, is 2, 8, 32 or 64 for `cfg_rate` 0, 1, 2 or 3. With `cfg_dbl`=1 it is 1, 4, 16 or 32. `done_flag` rises exactly 17 half-periods after the clock edge that takes the write.
- R4: `ss_n_o` is high while idle. It goes low on the clock edge that takes the write and returns high on the edge that sets `done_flag`.
- R5: While no transfer runs, `sck_o` rests at `cfg_cpol`. Data is launched on one SCK edge and sampled on the opposite edge: with `cfg_cpha`=0 it is sampled on the edge leaving the rest level, and with `cfg_cpha`=1 on the edge returning to it.
- R6: `done_flag` is set when a byte completes. `irq` is high exactly when `done_flag` and `cfg_irq_en` are both high.
- R7: A write while `busy` is high sets `wcol_flag` and does not change the byte being shifted.
- R8: `clr_flags` clears `done_flag` and `wcol_flag`. Any write clears `done_flag`, and a write while idle clears `wcol_flag`. Setting a flag takes priority over clearing it in the same cycle.
- R9: In slave mode, with `ss_n_i` low, the block samples `mosi_i` and drives `miso_o` on the SCK edges selected by R5. `done_flag` rises on the third rising clock edge after the eighth sampling edge appears on `sck_i`.
- R10: In slave mode, while `ss_n_i` is high, `miso_oe` is low, edges on `sck_i` have no effect, and any partially received byte is discarded.
- R11: After reset `ss_n_o`=1, `busy`=0, `done_flag`=0, `wcol_flag`=0, `irq`=0, `rdata`=0 and `miso_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 1 | Write strobe for the transmit byte |
| wdata | input | DATA_W | Byte to transmit |
| clr_flags | input | 1 | Clears done and collision flags |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_cpol | input | 1 | SCK rest level |
| cfg_cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| cfg_rate | input | 2 | Master divider select |
| cfg_dbl | input | 1 | Halves the master divider |
| cfg_irq_en | input | 1 | Lets done_flag drive irq |
| rdata | output | DATA_W | Last received byte |
| busy | output | 1 | Transfer in progress |
| done_flag | output | 1 | Transfer complete |
| wcol_flag | output | 1 | Write collision |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Master serial clock |
| ss_n_o | output | 1 | Master select, active low |
| mosi_o | output | 1 | Master data out |
| miso_i | input | 1 | Master data in |
| sck_i | input | 1 | Slave serial clock |
| ss_n_i | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data out enable |

## Verification
In master mode `done_flag` is due 17 half-periods after the rising edge that takes the write. For every rate and halving setting the bench checks that it is still low one cycle before that edge and high right after it. `ss_n_o` and the first `mosi_o` bit are due one edge after the write. In slave mode `done_flag` is due on the third rising edge after the bench moves `sck_i`, so the bench checks it low after two edges and high after three. All checks sample on the falling clock edge, and the bench counts edges from the write or pin change that triggers each result.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;
   localparam int RATE_W = 2;
   localparam int HALF_W = 7;

   typedef enum logic [1:0] {
      M_IDLE,
      M_SHIFT,
      M_HOLD
   } mst_state_e;

   // SCK half-period in system clocks for a rate code and halving option
   function automatic logic [HALF_W-1:0] half_period(input logic [RATE_W-1:0] rate,
                                                     input logic dbl);
      logic [HALF_W-1:0] h;
      case (rate)
         2'd0:    h = 7'd2;
         2'd1:    h = 7'd8;
         2'd2:    h = 7'd32;
         default: h = 7'd64;
      endcase
      return dbl ? (h >> 1) : h;
   endfunction
endpackage

// File: rtl/spi_xcvr_sync.sv
module spi_xcvr_sync #(
   parameter int              WIDTH   = 1,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_xcvr_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_xcvr_clkgen.sv
module spi_xcvr_clkgen #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] half,
   output logic             tick
);
   logic [CNT_W-1:0] cnt;

   if (CNT_W < 1) begin : g_bad_width
      $error("spi_xcvr_clkgen: CNT_W must be positive");
   end

   assign tick = run && (cnt == (half - CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run || tick)   cnt <= '0;
      else                     cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/spi_xcvr_shifter.sv
module spi_xcvr_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              lead,
   input  logic              trail,
   input  logic              cpha,
   input  logic              lsb_first,
   input  logic              sin,
   output logic              sout,
   output logic [DATA_W-1:0] rx_next,
   output logic              rx_fin
);
   localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] rx_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              lead_seen_q;
   logic              samp;
   logic              shft;

   assign samp    = !clear && (cpha ? trail : lead);
   assign shft    = !clear && (cpha ? (lead && lead_seen_q) : trail);
   assign rx_next = lsb_first ? {sin, rx_q[DATA_W-1:1]} : {rx_q[DATA_W-2:0], sin};
   assign rx_fin  = samp && (cnt_q == CNT_W'(DATA_W - 1));
   assign sout    = lsb_first ? sh_q[0] : sh_q[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sh_q <= '0;
      else if (load) sh_q <= load_data;
      else if (shft) sh_q <= lsb_first ? (sh_q >> 1) : (sh_q << 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q        <= '0;
         cnt_q       <= '0;
         lead_seen_q <= 1'b0;
      end else if (clear) begin
         rx_q        <= '0;
         cnt_q       <= '0;
         lead_seen_q <= 1'b0;
      end else begin
         if (samp) begin
            rx_q  <= rx_next;
            cnt_q <= rx_fin ? '0 : cnt_q + CNT_W'(1);
         end
         if (lead) lead_seen_q <= 1'b1;
      end
   end
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
   import spi_xcvr_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_data,
   input  logic [DATA_W-1:0] wdata,
   input  logic              clr_flags,
   input  logic              cfg_master,
   input  logic              cfg_lsb_first,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic [1:0]        cfg_rate,
   input  logic              cfg_dbl,
   input  logic              cfg_irq_en,
   output logic [DATA_W-1:0] rdata,
   output logic              busy,
   output logic              done_flag,
   output logic              wcol_flag,
   output logic              irq,
   output logic              sck_o,
   output logic              ss_n_o,
   output logic              mosi_o,
   input  logic              miso_i,
   input  logic              sck_i,
   input  logic              ss_n_i,
   input  logic              mosi_i,
   output logic              miso_o,
   output logic              miso_oe
);
   localparam int EDGES  = 2 * DATA_W;
   localparam int ECNT_W = $clog2(EDGES + 1);

   if (DATA_W < 2) begin : g_bad_data_w
      $error("spi_xcvr: DATA_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spi_xcvr: SYNC_STAGES must be at least 2");
   end

   // master sequencing state
   mst_state_e        mst_q;
   logic [ECNT_W-1:0] edge_q;
   logic              sck_q;
   logic              ss_q;
   logic              mst_idle;
   logic              tick;
   logic [HALF_W-1:0] half;

   // slave side synchronised pins
   logic [2:0]        sync_q;
   logic              sck_s, ss_s, mosi_s, sck_d;

   // shared shifter hookup
   logic              active, wr_ok, wr_col, mst_start;
   logic              m_edge, m_lead, m_trail;
   logic              s_edge, s_lead, s_trail, slv_act;
   logic              sh_lead, sh_trail, sh_clear, sh_sin, sh_out;
   logic [DATA_W-1:0] rx_next;
   logic              rx_fin, mst_fin, xfer_done;
   logic [DATA_W-1:0] rbuf_q;
   logic              done_q, wcol_q;

   assign half = half_period(cfg_rate, cfg_dbl);

   spi_xcvr_clkgen #(.CNT_W(HALF_W)) u_clkgen (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (!mst_idle),
      .half  (half),
      .tick  (tick)
   );

   spi_xcvr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sck_i, ss_n_i, mosi_i}),
      .q     (sync_q)
   );

   assign sck_s  = sync_q[2];
   assign ss_s   = sync_q[1];
   assign mosi_s = sync_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   assign mst_idle  = (mst_q == M_IDLE);
   assign slv_act   = !cfg_master && !ss_s;
   assign active    = !mst_idle || slv_act;
   assign wr_ok     = wr_data && !active;
   assign wr_col    = wr_data && active;
   assign mst_start = wr_ok && cfg_master;

   assign m_edge  = tick && (mst_q == M_SHIFT);
   assign m_lead  = m_edge && !edge_q[0];
   assign m_trail = m_edge && edge_q[0];
   assign mst_fin = tick && (mst_q == M_HOLD);

   assign s_edge  = slv_act && (sck_s != sck_d);
   assign s_lead  = s_edge && (sck_s != cfg_cpol);
   assign s_trail = s_edge && (sck_s == cfg_cpol);

   assign sh_lead  = cfg_master ? m_lead  : s_lead;
   assign sh_trail = cfg_master ? m_trail : s_trail;
   assign sh_clear = cfg_master ? mst_start : ss_s;
   assign sh_sin   = cfg_master ? miso_i : mosi_s;

   spi_xcvr_shifter #(.DATA_W(DATA_W)) u_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (sh_clear),
      .load      (wr_ok),
      .load_data (wdata),
      .lead      (sh_lead),
      .trail     (sh_trail),
      .cpha      (cfg_cpha),
      .lsb_first (cfg_lsb_first),
      .sin       (sh_sin),
      .sout      (sh_out),
      .rx_next   (rx_next),
      .rx_fin    (rx_fin)
   );

   assign xfer_done = cfg_master ? mst_fin : (rx_fin && slv_act);

   // master sequencer: 2*DATA_W SCK edges, then one quiet half-period
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mst_q  <= M_IDLE;
         edge_q <= '0;
         sck_q  <= 1'b0;
         ss_q   <= 1'b1;
      end else begin
         case (mst_q)
            M_IDLE: if (mst_start) begin
               mst_q  <= M_SHIFT;
               edge_q <= '0;
               sck_q  <= cfg_cpol;
               ss_q   <= 1'b0;
            end
            M_SHIFT: if (tick) begin
               sck_q  <= ~sck_q;
               edge_q <= edge_q + ECNT_W'(1);
               if (edge_q == ECNT_W'(EDGES - 1)) mst_q <= M_HOLD;
            end
            M_HOLD: if (tick) begin
               mst_q <= M_IDLE;
               ss_q  <= 1'b1;
            end
            default: mst_q <= M_IDLE;
         endcase
      end
   end

   // receive buffer and status flags (set has priority over clear)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbuf_q <= '0;
         done_q <= 1'b0;
         wcol_q <= 1'b0;
      end else begin
         if (rx_fin) rbuf_q <= rx_next;
         if (xfer_done)                  done_q <= 1'b1;
         else if (clr_flags || wr_data)  done_q <= 1'b0;
         if (wr_col)                     wcol_q <= 1'b1;
         else if (clr_flags || wr_ok)    wcol_q <= 1'b0;
      end
   end

   assign rdata     = rbuf_q;
   assign busy      = active;
   assign done_flag = done_q;
   assign wcol_flag = wcol_q;
   assign irq       = done_q && cfg_irq_en;
   assign sck_o     = mst_idle ? cfg_cpol : sck_q;
   assign ss_n_o    = ss_q;
   assign mosi_o    = cfg_master && sh_out;
   assign miso_o    = sh_out;
   assign miso_oe   = slv_act;
endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_data,
   input logic clr_flags,
   input logic busy,
   input logic done_flag,
   input logic wcol_flag,
   input logic irq,
   input logic sck_o,
   input logic ss_n_o,
   input logic miso_oe,
   input logic tick,
   input logic xfer_done,
   input logic ss_s,
   input logic mst_idle
);
   // R7
   wcol_on_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data && busy |=> wcol_flag);

   // R8
   flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_flags && !xfer_done && !(wr_data && busy) |=> !done_flag && !wcol_flag);

   // R6
   done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> done_flag);

   // R6
   irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done_flag);

   // R3
   sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mst_idle && !tick |=> $stable(sck_o));

   // R4
   ss_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mst_idle |-> ss_n_o);

   // R4
   ss_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mst_idle |-> !ss_n_o);

   // R10
   miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ss_s |-> !miso_oe);
endmodule

bind spi_xcvr spi_xcvr_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_data   (wr_data),
   .clr_flags (clr_flags),
   .busy      (busy),
   .done_flag (done_flag),
   .wcol_flag (wcol_flag),
   .irq       (irq),
   .sck_o     (sck_o),
   .ss_n_o    (ss_n_o),
   .miso_oe   (miso_oe),
   .tick      (tick),
   .xfer_done (xfer_done),
   .ss_s      (ss_s),
   .mst_idle  (mst_idle)
);

// File: tb/spi_xcvr_tb.sv
module spi_xcvr_tb;
   localparam int W = 8;
   localparam int H = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         rst_n;
   logic         wr_data = 0, clr_flags = 0;
   logic [W-1:0] wdata = '0;
   logic         cfg_master = 1, cfg_lsb_first = 0, cfg_cpol = 0, cfg_cpha = 0;
   logic [1:0]   cfg_rate = 0;
   logic         cfg_dbl = 0, cfg_irq_en = 0;
   logic [W-1:0] rdata;
   logic         busy, done_flag, wcol_flag, irq;
   logic         sck_o, ss_n_o, mosi_o;
   logic         miso_i = 0;
   logic         sck_i = 0, ss_n_i = 1, mosi_i = 0;
   logic         miso_o, miso_oe;

   int checks = 0;
   int errors = 0;

   spi_xcvr #(.DATA_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wdata(wdata), .clr_flags(clr_flags),
      .cfg_master(cfg_master), .cfg_lsb_first(cfg_lsb_first), .cfg_cpol(cfg_cpol),
      .cfg_cpha(cfg_cpha), .cfg_rate(cfg_rate), .cfg_dbl(cfg_dbl), .cfg_irq_en(cfg_irq_en),
      .rdata(rdata), .busy(busy), .done_flag(done_flag), .wcol_flag(wcol_flag), .irq(irq),
      .sck_o(sck_o), .ss_n_o(ss_n_o), .mosi_o(mosi_o), .miso_i(miso_i),
      .sck_i(sck_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i), .miso_o(miso_o), .miso_oe(miso_oe)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic pick(input logic [W-1:0] b, input int i, input bit lsb);
      return lsb ? b[i] : b[W-1-i];
   endfunction

   function automatic int exp_half(input logic [1:0] rate, input bit dbl);
      int h;
      case (rate)
         2'd0: h = 2;
         2'd1: h = 8;
         2'd2: h = 32;
         default: h = 64;
      endcase
      return dbl ? h / 2 : h;
   endfunction

   // bench slave for master-mode runs
   logic [W-1:0] m_tx = '0, m_rx = '0;
   int           m_idx = 0;
   bit           m_lead_seen = 0;
   logic         m_lead;

   always @(negedge ss_n_o) begin
      m_idx = 0;
      m_lead_seen = 0;
      m_rx = '0;
      miso_i = pick(m_tx, 0, cfg_lsb_first);
   end

   always @(sck_o) begin
      if (rst_n === 1'b1 && ss_n_o === 1'b0) begin
         m_lead = (sck_o != cfg_cpol);
         if (m_lead != cfg_cpha) begin
            m_rx = cfg_lsb_first ? {mosi_o, m_rx[W-1:1]} : {m_rx[W-2:0], mosi_o};
         end else if (!cfg_cpha || m_lead_seen) begin
            m_idx++;
            if (m_idx < W) miso_i = pick(m_tx, m_idx, cfg_lsb_first);
         end
         if (m_lead) m_lead_seen = 1;
      end
   end

   task automatic write_byte(input logic [W-1:0] b);
      wdata   = b;
      wr_data = 1;
      @(negedge clk);
      wr_data = 0;
   endtask

   task automatic mst_xfer(input logic [W-1:0] mb, input logic [W-1:0] sb, input bit lsb,
                           input bit cpol, input bit cpha, input logic [1:0] rate,
                           input bit dbl, input bit ien);
      int h;
      h = exp_half(rate, dbl);
      cfg_master = 1; cfg_lsb_first = lsb; cfg_cpol = cpol; cfg_cpha = cpha;
      cfg_rate = rate; cfg_dbl = dbl; cfg_irq_en = ien;
      m_tx = sb;
      @(negedge clk);
      chk(sck_o == cpol, "R5 idle sck level", sck_o, cpol);
      write_byte(mb);
      chk(ss_n_o == 0, "R4 select low after write", ss_n_o, 0);
      chk(done_flag == 0, "R8 write clears done", done_flag, 0);
      chk(mosi_o == pick(mb, 0, lsb), "R2 first bit on mosi", mosi_o, pick(mb, 0, lsb));
      repeat (17 * h - 1) @(negedge clk);
      chk(done_flag == 0, "R3 done not early", done_flag, 0);
      clr_flags = 1;
      @(negedge clk);
      clr_flags = 0;
      chk(done_flag == 1, "R3/R8 done on time, set beats clear", done_flag, 1);
      chk(ss_n_o == 1, "R4 select high at end", ss_n_o, 1);
      chk(rdata == sb, "R1/R2 received byte", rdata, sb);
      chk(m_rx == mb, "R1/R5 transmitted byte", m_rx, mb);
      chk(irq == ien, "R6 irq gating", irq, ien);
   endtask

   task automatic slv_edge_done_check();
      repeat (2) @(negedge clk);
      chk(done_flag == 0, "R9 slave done not early", done_flag, 0);
      @(negedge clk);
      chk(done_flag == 1, "R9 slave done on time", done_flag, 1);
      repeat (H - 3) @(negedge clk);
   endtask

   task automatic slv_xfer(input logic [W-1:0] mb, input logic [W-1:0] sb, input bit lsb,
                           input bit cpol, input bit cpha);
      logic [W-1:0] got;
      got = '0;
      cfg_master = 0; cfg_lsb_first = lsb; cfg_cpol = cpol; cfg_cpha = cpha;
      sck_i = cpol; ss_n_i = 1; mosi_i = 0;
      repeat (4) @(negedge clk);
      write_byte(sb);
      chk(wcol_flag == 0, "R8 idle write leaves no collision", wcol_flag, 0);
      ss_n_i = 0;
      repeat (H) @(negedge clk);
      chk(miso_oe == 1, "R9 miso driven under select", miso_oe, 1);
      for (int i = 0; i < W; i++) begin
         if (!cpha) begin
            mosi_i = pick(mb, i, lsb);
            repeat (H) @(negedge clk);
            if (lsb) got[i] = miso_o; else got[W-1-i] = miso_o;
            sck_i = ~cpol;
            if (i == W - 1) slv_edge_done_check(); else repeat (H) @(negedge clk);
            sck_i = cpol;
            repeat (H) @(negedge clk);
         end else begin
            sck_i = ~cpol;
            mosi_i = pick(mb, i, lsb);
            repeat (H) @(negedge clk);
            if (lsb) got[i] = miso_o; else got[W-1-i] = miso_o;
            sck_i = cpol;
            if (i == W - 1) slv_edge_done_check(); else repeat (H) @(negedge clk);
         end
      end
      ss_n_i = 1;
      repeat (4) @(negedge clk);
      chk(rdata == mb, "R9 slave received byte", rdata, mb);
      chk(got == sb, "R9 slave transmitted byte", got, sb);
      chk(miso_oe == 0, "R10 miso released", miso_oe, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] a, b;
      void'($urandom(32'd2024));
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      chk(ss_n_o == 1, "R11 ss_n_o", ss_n_o, 1);
      chk(busy == 0, "R11 busy", busy, 0);
      chk(done_flag == 0 && wcol_flag == 0 && irq == 0, "R11 flags", {done_flag, wcol_flag, irq}, 0);
      chk(rdata == 0, "R11 rdata", rdata, 0);
      chk(miso_oe == 0, "R11 miso_oe", miso_oe, 0);

      // directed bit order, then every rate / halving pair
      mst_xfer(8'h01, 8'h80, 1, 0, 0, 2'd0, 0, 1);
      mst_xfer(8'h01, 8'h80, 0, 0, 0, 2'd0, 0, 1);
      for (int r = 0; r < 8; r++) begin
         mst_xfer(W'($urandom), W'($urandom), $urandom % 2, $urandom % 2, $urandom % 2,
                  2'(r % 4), r / 4, $urandom % 2);
      end
      for (int k = 0; k < 6; k++) begin
         mst_xfer(W'($urandom), W'($urandom), $urandom % 2, $urandom % 2, $urandom % 2,
                  2'($urandom), $urandom % 2, $urandom % 2);
      end

      // R7 collision keeps the shifting byte; R8 explicit clear
      a = 8'hA5; b = 8'h3C;
      cfg_master = 1; cfg_lsb_first = 0; cfg_cpol = 0; cfg_cpha = 1;
      cfg_rate = 2'd1; cfg_dbl = 0; m_tx = b;
      @(negedge clk);
      write_byte(a);
      repeat (20) @(negedge clk);
      write_byte(8'hFF);
      chk(wcol_flag == 1, "R7 collision flag", wcol_flag, 1);
      while (!done_flag) @(negedge clk);
      chk(m_rx == a, "R7 byte not corrupted", m_rx, a);
      chk(rdata == b, "R7 receive intact", rdata, b);
      clr_flags = 1;
      @(negedge clk);
      clr_flags = 0;
      chk(done_flag == 0 && wcol_flag == 0, "R8 clear strobe", {done_flag, wcol_flag}, 0);

      // slave exchanges in all four clock modes plus random
      for (int m = 0; m < 4; m++) begin
         slv_xfer(W'($urandom), W'($urandom), m % 2, m / 2, m % 2);
      end

      // R10 ignored clock with select high, then a partial byte discarded
      cfg_master = 0; cfg_cpol = 0; cfg_cpha = 0;
      write_byte(8'h00);
      for (int i = 0; i < 2 * W; i++) begin
         sck_i = ~sck_i; mosi_i = $urandom % 2;
         repeat (H) @(negedge clk);
      end
      chk(done_flag == 0, "R10 clock ignored under high select", done_flag, 0);
      chk(miso_oe == 0, "R10 miso off under high select", miso_oe, 0);
      sck_i = 0;
      ss_n_i = 0;
      repeat (H) @(negedge clk);
      for (int i = 0; i < 6; i++) begin
         sck_i = ~sck_i;
         repeat (H) @(negedge clk);
      end
      ss_n_i = 1;
      repeat (H) @(negedge clk);
      slv_xfer(8'hC3, 8'h5A, 0, 0, 0);
      slv_xfer(W'($urandom), W'($urandom), 1, 1, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule